// File: doc/BRIEF.md
# Multi-Port Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processor cores use to claim shared resources. Each semaphore is one 32-bit word on a small register bus. A core claims a semaphore with a single write that sets the lock flag and carries the core's own tag. It then reads the word back. The claim has succeeded only if the word shows the lock flag together with that same tag. A core gives a semaphore back by writing its tag with the lock flag clear.

Every semaphore is a two-state machine with the states `SEM_FREE` and `SEM_HELD`. It has four named transitions. TAKE goes from `SEM_FREE` to `SEM_HELD` on a lock write. RELEASE goes from `SEM_HELD` to `SEM_FREE` on a clear write from the owner. REJECT keeps `SEM_HELD` on any lock write. IGNORE keeps `SEM_HELD` on a clear write from a tag that is not the owner.

The bank has several bus ports, one for each master, and every port has its own master-ID input. When the cross-check option is on, the block accepts a write only if the tag in the write data equals that port's master ID. When more than one port writes the same semaphore in the same cycle, only the write from the lowest-numbered port is applied. The state of a semaphore is therefore always decided by exactly one write.

Top module: `hsem_bank`

## Requirements
- R1: After reset, and at any time while the asynchronous active-low reset is held, every semaphore is free and reads as zero.
- R2: Semaphore i sits at byte offset 4*i, and address bits [1:0] are ignored. A held semaphore reads as bit 31 set, the owner tag in bits [8+ID_W-1:8], and every other bit zero. A free semaphore reads as all zeros. The write encoding is: bit 31 = 1 requests a lock, bit 31 = 0 requests a release, and the tag is taken from bits [8+ID_W-1:8]. Tag 1 is bit 8.
- R3: A lock write to a free semaphore performs TAKE. The owner tag is taken from that same write, and the new owner can be read in the next cycle.
- R4: A lock write to a held semaphore performs REJECT. This is true whichever tag the write carries, and the owner does not change.
- R5: A clear write whose tag equals the stored owner performs RELEASE, and the semaphore then reads as zero.
- R6: A clear write whose tag differs from the stored owner performs IGNORE, and the semaphore stays held by its owner.
- R7: With CHECK_ID = 1, a write whose tag differs from the master-ID input of its port has no effect.
- R8: When several ports write the same semaphore in one cycle, only the lowest-numbered port's write is applied. The writes from the other ports are dropped.
- R9: Word indices at NUM_SEMS or above read as zero, and writes to them change no semaphore. They do not wrap onto a lower index.
- R10: Write-data bits outside the lock flag and the tag field are ignored and never appear in read data.
- R11: Writes from different ports to different semaphores in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | NUM_PORTS x ADDR_W | Byte address for each port |
| bus_we | input | NUM_PORTS | Write strobe for each port, single cycle |
| bus_wdata | input | NUM_PORTS x 32 | Write data for each port |
| bus_mid | input | NUM_PORTS x ID_W | Master ID of the master attached to each port |
| bus_rdata | output | NUM_PORTS x 32 | Read data for each port, combinational from the addressed word |

## Verification
The bench builds the block with its default parameters: 32 semaphores, two ports, 8-bit tags, an 8-bit byte address, and CHECK_ID = 1. The 8-bit address reaches word indices 32 to 63, so writes just past the last semaphore can be shown to neither wrap nor have any effect. With two ports, the bench can drive same-cycle collisions on one semaphore, including a release on port 0 that meets a lock request on port 1. It can also drive parallel claims on different semaphores. The bench feeds tags that disagree with the port's master ID so that the cross-check path is exercised.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
    localparam int WORD_W   = 32;
    localparam int LOCK_POS = 31;
    localparam int ID_LSB   = 8;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_state_e;
endpackage

// File: rtl/hsem_dec.sv
// Per-port request decoder: word index, range check, field split, tag cross-check.
module hsem_dec
    import hsem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SEMS = 32,
    parameter int ID_W     = 8,
    parameter bit CHECK_ID = 1'b1,
    localparam int WIDX_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ID_W-1:0]   mid,
    output logic [WIDX_W-1:0] widx,
    output logic              in_range,
    output logic              wr_ok,
    output logic              lock,
    output logic [ID_W-1:0]   id
);
    logic tag_ok;
    logic unused_bits;

    assign widx     = addr[ADDR_W-1:2];
    assign in_range = (32'(widx) < NUM_SEMS);
    assign lock     = wdata[LOCK_POS];
    assign id       = wdata[ID_LSB +: ID_W];
    assign tag_ok   = (!CHECK_ID) || (id == mid);
    assign wr_ok    = we && in_range && tag_ok;

    assign unused_bits = ^{addr[1:0], wdata[LOCK_POS-1:ID_LSB+ID_W], wdata[ID_LSB-1:0]};
endmodule

// File: rtl/hsem_arb.sv
// Per-semaphore write selector: lowest-numbered requesting port wins.
module hsem_arb #(
    parameter int NUM_PORTS = 2,
    parameter int ID_W      = 8,
    parameter int WIDX_W    = 6,
    parameter int SLOT      = 0
) (
    input  logic [NUM_PORTS-1:0]             req,
    input  logic [NUM_PORTS-1:0][WIDX_W-1:0] widx,
    input  logic [NUM_PORTS-1:0]             lock,
    input  logic [NUM_PORTS-1:0][ID_W-1:0]   id,
    output logic                             wr_en,
    output logic                             wr_lock,
    output logic [ID_W-1:0]                  wr_id
);
    always_comb begin
        wr_en   = 1'b0;
        wr_lock = 1'b0;
        wr_id   = '0;
        // Walk from the highest port down so the lowest match is applied last.
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (req[p] && (widx[p] == WIDX_W'(SLOT))) begin
                wr_en   = 1'b1;
                wr_lock = lock[p];
                wr_id   = id[p];
            end
        end
    end
endmodule

// File: rtl/hsem_slot.sv
// One semaphore: FREE/HELD state machine with owner tag.
module hsem_slot
    import hsem_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [ID_W-1:0]   wr_id,
    output logic              held,
    output logic [ID_W-1:0]   owner,
    output logic [WORD_W-1:0] rdata
);
    sem_state_e      state_q, state_d;
    logic [ID_W-1:0] owner_q, owner_d;

    // Next-state logic: TAKE, RELEASE, REJECT, IGNORE.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            SEM_FREE: begin
                if (wr_en && wr_lock) begin          // TAKE
                    state_d = SEM_HELD;
                    owner_d = wr_id;
                end
            end
            SEM_HELD: begin
                if (wr_en && !wr_lock && (wr_id == owner_q)) begin  // RELEASE
                    state_d = SEM_FREE;
                    owner_d = '0;
                end
                // lock writes (REJECT) and foreign clears (IGNORE) keep the state
            end
            default: begin
                state_d = SEM_FREE;
                owner_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEM_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Outputs.
    always_comb begin
        rdata = '0;
        held  = (state_q == SEM_HELD);
        owner = owner_q;
        if (state_q == SEM_HELD) begin
            rdata[LOCK_POS]         = 1'b1;
            rdata[ID_LSB +: ID_W]   = owner_q;
        end
    end
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int NUM_SEMS  = 32,
    parameter int NUM_PORTS = 2,
    parameter int ID_W      = 8,
    parameter int ADDR_W    = 8,
    parameter bit CHECK_ID  = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] bus_addr,
    input  logic [NUM_PORTS-1:0]             bus_we,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0] bus_wdata,
    input  logic [NUM_PORTS-1:0][ID_W-1:0]   bus_mid,
    output logic [NUM_PORTS-1:0][WORD_W-1:0] bus_rdata
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [NUM_PORTS-1:0][WIDX_W-1:0] p_widx;
    logic [NUM_PORTS-1:0]             p_in_range;
    logic [NUM_PORTS-1:0]             p_wr_ok;
    logic [NUM_PORTS-1:0]             p_lock;
    logic [NUM_PORTS-1:0][ID_W-1:0]   p_id;

    logic [NUM_SEMS-1:0]              sem_held;
    logic [NUM_SEMS-1:0][ID_W-1:0]    sem_owner;
    logic [NUM_SEMS-1:0][WORD_W-1:0]  sem_rdata;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hsem_dec #(
            .ADDR_W  (ADDR_W),
            .NUM_SEMS(NUM_SEMS),
            .ID_W    (ID_W),
            .CHECK_ID(CHECK_ID)
        ) u_dec (
            .addr    (bus_addr[p]),
            .we      (bus_we[p]),
            .wdata   (bus_wdata[p]),
            .mid     (bus_mid[p]),
            .widx    (p_widx[p]),
            .in_range(p_in_range[p]),
            .wr_ok   (p_wr_ok[p]),
            .lock    (p_lock[p]),
            .id      (p_id[p])
        );
    end

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
        logic            wr_en;
        logic            wr_lock;
        logic [ID_W-1:0] wr_id;

        hsem_arb #(
            .NUM_PORTS(NUM_PORTS),
            .ID_W     (ID_W),
            .WIDX_W   (WIDX_W),
            .SLOT     (s)
        ) u_arb (
            .req    (p_wr_ok),
            .widx   (p_widx),
            .lock   (p_lock),
            .id     (p_id),
            .wr_en  (wr_en),
            .wr_lock(wr_lock),
            .wr_id  (wr_id)
        );

        hsem_slot #(
            .ID_W(ID_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_lock(wr_lock),
            .wr_id  (wr_id),
            .held   (sem_held[s]),
            .owner  (sem_owner[s]),
            .rdata  (sem_rdata[s])
        );
    end

    // Read path: addressed word, zero when out of range.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int s = 0; s < NUM_SEMS; s++) begin
                if (p_in_range[p] && (p_widx[p] == WIDX_W'(s))) begin
                    bus_rdata[p] = sem_rdata[s];
                end
            end
        end
    end
endmodule

// File: rtl/hsem_bank_chk.sv
module hsem_bank_chk
    import hsem_pkg::*;
#(
    parameter int NUM_SEMS  = 32,
    parameter int NUM_PORTS = 2,
    parameter int ID_W      = 8,
    parameter int ADDR_W    = 8,
    parameter bit CHECK_ID  = 1'b1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0] bus_addr,
    input logic [NUM_PORTS-1:0]             bus_we,
    input logic [NUM_PORTS-1:0][WORD_W-1:0] bus_wdata,
    input logic [NUM_PORTS-1:0][ID_W-1:0]   bus_mid,
    input logic [NUM_PORTS-1:0][WORD_W-1:0] bus_rdata,
    input logic [NUM_SEMS-1:0]              sem_held,
    input logic [NUM_SEMS-1:0][ID_W-1:0]    sem_owner
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] KEEP_MASK =
        (WORD_W'(1) << LOCK_POS) | (((WORD_W'(1) << ID_W) - WORD_W'(1)) << ID_LSB);

    logic            p0_tag_ok;
    logic [ID_W-1:0] p0_id;
    assign p0_id     = bus_wdata[0][ID_LSB +: ID_W];
    assign p0_tag_ok = (!CHECK_ID) || (p0_id == bus_mid[0]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        logic [WIDX_W-1:0] wi;
        assign wi = bus_addr[p][ADDR_W-1:2];

        assert_oob_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(wi) >= NUM_SEMS) |-> (bus_rdata[p] == '0));

        assert_free_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_rdata[p][LOCK_POS] |-> (bus_rdata[p] == '0));

        assert_clean_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ((bus_rdata[p] & ~KEEP_MASK) == '0));
    end

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem_chk
        logic p0_hit;
        logic any_clear;
        assign p0_hit = bus_we[0] && p0_tag_ok && (bus_addr[0][ADDR_W-1:2] == WIDX_W'(s));

        always_comb begin
            any_clear = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_we[p] && !bus_wdata[p][LOCK_POS]
                    && (bus_addr[p][ADDR_W-1:2] == WIDX_W'(s))) begin
                    any_clear = 1'b1;
                end
            end
        end

        // R3 and R8: port 0 always wins a free semaphore.
        assert_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (p0_hit && bus_wdata[0][LOCK_POS] && !sem_held[s])
            |=> (sem_held[s] && (sem_owner[s] == $past(p0_id))));

        assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (p0_hit && !bus_wdata[0][LOCK_POS] && sem_held[s] && (p0_id == sem_owner[s]))
            |=> !sem_held[s]);

        // R4 and R6: only a clear write can disturb a held semaphore.
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sem_held[s] && !any_clear) |=> (sem_held[s] && $stable(sem_owner[s])));
    end
endmodule

bind hsem_bank hsem_bank_chk #(
    .NUM_SEMS (NUM_SEMS),
    .NUM_PORTS(NUM_PORTS),
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .CHECK_ID (CHECK_ID)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_mid  (bus_mid),
    .bus_rdata(bus_rdata),
    .sem_held (sem_held),
    .sem_owner(sem_owner)
);

// File: tb/hsem_bank_test.sv
module hsem_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0][7:0]  bus_addr  = '0;
    logic [1:0]       bus_we    = '0;
    logic [1:0][31:0] bus_wdata = '0;
    logic [1:0][7:0]  bus_mid   = '0;
    logic [1:0][31:0] bus_rdata;

    int n_checks = 0;
    int n_err    = 0;

    always #5 clk = ~clk;

    hsem_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_mid  (bus_mid),
        .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic        port;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [7:0]  mid;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000, 4'd1},  // R1 free
        '{1'b0, 1'b1, 8'h04, 32'h8000_0100, 8'h01, 32'h8000_0100, 4'd3},  // R3 take
        '{1'b1, 1'b1, 8'h04, 32'h8000_0200, 8'h02, 32'h8000_0100, 4'd4},  // R4 reject
        '{1'b1, 1'b1, 8'h04, 32'h0000_0200, 8'h02, 32'h8000_0100, 4'd6},  // R6 ignore
        '{1'b0, 1'b1, 8'h04, 32'h0000_0100, 8'h01, 32'h0000_0000, 4'd5},  // R5 release
        '{1'b1, 1'b1, 8'h04, 32'h8000_0200, 8'h02, 32'h8000_0200, 4'd3},  // R3 retake
        '{1'b1, 1'b1, 8'h7C, 32'h8000_0200, 8'h02, 32'h8000_0200, 4'd2},  // R2 last slot
        '{1'b0, 1'b0, 8'h78, 32'h0000_0000, 8'h00, 32'h0000_0000, 4'd2},  // R2 neighbour
        '{1'b0, 1'b1, 8'h80, 32'h8000_0100, 8'h01, 32'h0000_0000, 4'd9},  // R9 oob
        '{1'b0, 1'b1, 8'h08, 32'h8000_0100, 8'h02, 32'h0000_0000, 4'd7},  // R7 bad tag
        '{1'b0, 1'b1, 8'h0C, 32'hFFFF_01FF, 8'h01, 32'h8000_0100, 4'd10}, // R10 junk bits
        '{1'b1, 1'b1, 8'h0C, 32'h8000_0100, 8'h01, 32'h8000_0100, 4'd4},  // R4 same tag
        '{1'b0, 1'b1, 8'h7C, 32'h0000_0200, 8'h02, 32'h0000_0000, 4'd5}   // R5 via port 0
    };

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d, input logic [7:0] m);
        @(negedge clk);
        bus_addr[p]  = a;
        bus_wdata[p] = d;
        bus_mid[p]   = m;
        bus_we[p]    = 1'b1;
        @(negedge clk);
        bus_we = '0;
    endtask

    task automatic wr2(input logic [7:0] a0, input logic [31:0] d0, input logic [7:0] m0,
                       input logic [7:0] a1, input logic [31:0] d1, input logic [7:0] m1);
        @(negedge clk);
        bus_addr[0] = a0; bus_wdata[0] = d0; bus_mid[0] = m0;
        bus_addr[1] = a1; bus_wdata[1] = d1; bus_mid[1] = m1;
        bus_we = 2'b11;
        @(negedge clk);
        bus_we = '0;
    endtask

    task automatic rd_check(input int p, input logic [7:0] a, input logic [31:0] exp,
                            input int req, input string what);
        bus_addr[p] = a;
        #1;
        n_checks++;
        if (bus_rdata[p] !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: port %0d addr %h got %h expected %h",
                     req, what, p, a, bus_rdata[p], exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state visible on both ports while reset is held
        rd_check(0, 8'h04, 32'h0, 1, "R1 under reset");
        rst_n = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 32; w++) begin
                rd_check(p, 8'(w * 4), 32'h0, 1, "R1 free after reset");
            end
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(int'(VECS[i].port), VECS[i].addr, VECS[i].wdata, VECS[i].mid);
            rd_check(int'(VECS[i].port), VECS[i].addr, VECS[i].exp, int'(VECS[i].req), "vector");
        end

        // R8: both ports lock slot 5 together, port 0 wins
        wr2(8'h14, 32'h8000_0100, 8'h01, 8'h14, 32'h8000_0200, 8'h02);
        rd_check(0, 8'h14, 32'h8000_0100, 8, "R8 collision port0");
        rd_check(1, 8'h14, 32'h8000_0100, 8, "R8 collision port1 view");
        // R8: port 0 release meets port 1 lock, only the release lands
        wr2(8'h14, 32'h0000_0100, 8'h01, 8'h14, 32'h8000_0200, 8'h02);
        rd_check(1, 8'h14, 32'h0, 8, "R8 release beats lock");

        // R11: parallel claims on different semaphores
        wr2(8'h18, 32'h8000_0100, 8'h01, 8'h1C, 32'h8000_0200, 8'h02);
        rd_check(0, 8'h18, 32'h8000_0100, 11, "R11 port0 claim");
        rd_check(1, 8'h1C, 32'h8000_0200, 11, "R11 port1 claim");

        // R2: low address bits ignored
        wr(0, 8'h23, 32'h8000_0100, 8'h01);
        rd_check(1, 8'h20, 32'h8000_0100, 2, "R2 low bits alias");

        // R1: asynchronous reset mid-run frees everything
        @(negedge clk);
        rst_n = 1'b0;
        rd_check(0, 8'h20, 32'h0, 1, "R1 mid-run reset");
        rd_check(1, 8'h04, 32'h0, 1, "R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R9: a write one word past the end does not wrap onto word 1
        wr(0, 8'h84, 32'h8000_0100, 8'h01);
        rd_check(0, 8'h04, 32'h0, 9, "R9 no wrap");
        rd_check(0, 8'h84, 32'h0, 9, "R9 oob read");

        // R7: release with mismatched master ID is dropped
        wr(1, 8'h28, 32'h8000_0200, 8'h02);
        wr(1, 8'h28, 32'h0000_0200, 8'h03);
        rd_check(1, 8'h28, 32'h8000_0200, 7, "R7 release with bad master id");

        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule